// File: doc/BRIEF.md
# Programmable CRT Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display together with the frame-buffer address that the pixel fetch engine reads from. It runs on the fetch clock. Each clock cycle stands for one 64-bit memory unit, which is 8, 4 or 2 pixels at 8, 16 or 32 bits per pixel. For that reason every horizontal quantity is programmed in units, not in pixels. In both axes the blank interval is given as one total width, and the front porch and sync pulse lie inside it.

Software programs the raster through a 32-bit register port. Write and read are separate and each takes a byte offset. Timing, control, base and pitch writes are held in staging registers and are copied into the working set at the end of a frame, so a mode change never tears a frame. The line-interrupt compare value is used as soon as it is written. A zoom bit shows each fetched line twice: the line fetch address moves forward by the pitch only after every second active line. Software programs the vertical counts already doubled.

Top module: `crt_raster_gen`

## Requirements
- R1: While reset is held, hsync, vsync and line_irq are 0, fetch_addr is 0, the line readback is 0, and the line-interrupt register (offset 0x2C) reads 0xFFF.
- R2: A line lasts H_ACT+H_BLK clock cycles. Offset 0x0C holds H_ACT and offset 0x10 holds H_BLK, both in units. The horizontal position h counts from 0, and the line is horizontally active while h < H_ACT.
- R3: The sync level before polarity is high for H_ACT+H_FP <= h < H_ACT+H_FP+H_SW. H_FP is at offset 0x14 and H_SW at 0x18. Vertical sync uses the same rule on the line number v, with V_ACT, V_BLK, V_FP and V_SW at offsets 0x1C, 0x20, 0x24 and 0x28.
- R4: A frame has V_ACT+V_BLK lines. active_video is 1 only when h < H_ACT and v < V_ACT, and blank is always its inverse.
- R5: In the control register (offset 0x00), bit 1 inverts hsync and bit 2 inverts vsync. Both syncs are active-high when these bits are 0.
- R6: fetch_addr equals the line address plus 8*h. The line address takes the base register (offset 0x04) at each frame start. It grows by the pitch register (offset 0x08) at the end of each line with v < V_ACT.
- R7: With control bit 0 (zoom) set, the line address grows only at the end of active lines with odd v. Each fetched line is therefore shown twice.
- R8: Writes to offsets 0x00 to 0x28 change the raster only from the next frame start. The rest of the current frame keeps the old settings.
- R9: Reading offset 0x30 returns the current line number v.
- R10: line_irq is high for exactly the one cycle with h = 0 and v equal to the value at offset 0x2C. A new value applies at once.
- R11: Each writable register reads back the last value written, cut to its width: 3 bits for control, 32 for base and pitch, 12 for the others. Writes to offset 0x30 or to unmapped offsets change nothing, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fetch clock, one 64-bit unit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data for rd_addr |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| blank | output | 1 | High outside the active area |
| active_video | output | 1 | High inside the active area |
| line_irq | output | 1 | One-cycle raster-line interrupt |
| fetch_addr | output | 32 | Frame-buffer byte address of the current unit |

## Verification
The hardest situation to reach is a register write that lands in the middle of a frame. The bench has to prove that the old geometry holds for the rest of that frame and that the new geometry starts exactly at the frame boundary. To get there, the bench locks onto the frame start, which it sees at the ports as the first active cycle on line 0. It then counts cycles to a known position on line 1, writes a narrower active width there, and samples a unit that lies inside the old active width but outside the new one. After that it scans a whole frame under the new width. Zoom is checked by scanning a full frame and comparing fetch_addr against the line-pair advance in every cycle.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int CRT_CNT_W   = 12;
  localparam int CRT_ADDR_W  = 32;
  localparam int CRT_DATA_W  = 32;
  localparam int CRT_REG_AW  = 8;
  localparam int CRT_UNIT_SHIFT = 3;  // 64-bit unit = 8 bytes

  typedef logic [CRT_CNT_W-1:0]  cnt_t;
  typedef logic [CRT_ADDR_W-1:0] addr_t;
  typedef logic [CRT_DATA_W-1:0] data_t;
  typedef logic [CRT_REG_AW-1:0] regaddr_t;

  typedef struct packed {
    logic  zoom;
    logic  hs_inv;
    logic  vs_inv;
    addr_t base;
    addr_t pitch;
    cnt_t  h_act;
    cnt_t  h_blk;
    cnt_t  h_fp;
    cnt_t  h_sw;
    cnt_t  v_act;
    cnt_t  v_blk;
    cnt_t  v_fp;
    cnt_t  v_sw;
  } crt_cfg_t;

  localparam regaddr_t OFS_CTRL  = 8'h00;
  localparam regaddr_t OFS_BASE  = 8'h04;
  localparam regaddr_t OFS_PITCH = 8'h08;
  localparam regaddr_t OFS_HACT  = 8'h0C;
  localparam regaddr_t OFS_HBLK  = 8'h10;
  localparam regaddr_t OFS_HFP   = 8'h14;
  localparam regaddr_t OFS_HSW   = 8'h18;
  localparam regaddr_t OFS_VACT  = 8'h1C;
  localparam regaddr_t OFS_VBLK  = 8'h20;
  localparam regaddr_t OFS_VFP   = 8'h24;
  localparam regaddr_t OFS_VSW   = 8'h28;
  localparam regaddr_t OFS_IRQ   = 8'h2C;
  localparam regaddr_t OFS_LINE  = 8'h30;
endpackage

// File: rtl/crt_reg_bank.sv
module crt_reg_bank
  import crt_pkg::*;
#(
  parameter crt_cfg_t RST_CFG = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  regaddr_t wr_addr,
  input  data_t    wr_data,
  input  regaddr_t rd_addr,
  input  logic     frame_end,
  input  cnt_t     cur_line,
  output crt_cfg_t cfg_live,
  output crt_cfg_t cfg_act,
  output cnt_t     irq_line,
  output data_t    rd_data
);

  crt_cfg_t live_d;
  cnt_t     irq_d;
  cnt_t     wr_cnt;

  assign wr_cnt = wr_data[CRT_CNT_W-1:0];

  // next state of the staging registers
  always_comb begin
    live_d = cfg_live;
    irq_d  = irq_line;
    if (wr_en) begin
      unique case (wr_addr)
        OFS_CTRL: begin
          live_d.zoom   = wr_data[0];
          live_d.hs_inv = wr_data[1];
          live_d.vs_inv = wr_data[2];
        end
        OFS_BASE:  live_d.base  = wr_data;
        OFS_PITCH: live_d.pitch = wr_data;
        OFS_HACT:  live_d.h_act = wr_cnt;
        OFS_HBLK:  live_d.h_blk = wr_cnt;
        OFS_HFP:   live_d.h_fp  = wr_cnt;
        OFS_HSW:   live_d.h_sw  = wr_cnt;
        OFS_VACT:  live_d.v_act = wr_cnt;
        OFS_VBLK:  live_d.v_blk = wr_cnt;
        OFS_VFP:   live_d.v_fp  = wr_cnt;
        OFS_VSW:   live_d.v_sw  = wr_cnt;
        OFS_IRQ:   irq_d        = wr_cnt;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_live <= RST_CFG;
      irq_line <= '1;
    end else begin
      cfg_live <= live_d;
      irq_line <= irq_d;
    end
  end

  // working set, copied at the frame boundary only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_act <= RST_CFG;
    end else if (frame_end) begin
      cfg_act <= cfg_live;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      OFS_CTRL:  rd_data = data_t'({cfg_live.vs_inv, cfg_live.hs_inv, cfg_live.zoom});
      OFS_BASE:  rd_data = cfg_live.base;
      OFS_PITCH: rd_data = cfg_live.pitch;
      OFS_HACT:  rd_data = data_t'(cfg_live.h_act);
      OFS_HBLK:  rd_data = data_t'(cfg_live.h_blk);
      OFS_HFP:   rd_data = data_t'(cfg_live.h_fp);
      OFS_HSW:   rd_data = data_t'(cfg_live.h_sw);
      OFS_VACT:  rd_data = data_t'(cfg_live.v_act);
      OFS_VBLK:  rd_data = data_t'(cfg_live.v_blk);
      OFS_VFP:   rd_data = data_t'(cfg_live.v_fp);
      OFS_VSW:   rd_data = data_t'(cfg_live.v_sw);
      OFS_IRQ:   rd_data = data_t'(irq_line);
      OFS_LINE:  rd_data = data_t'(cur_line);
      default:   rd_data = '0;
    endcase
  end

endmodule

// File: rtl/crt_axis_counter.sv
module crt_axis_counter
  import crt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  cnt_t act_len,
  input  cnt_t blk_len,
  input  cnt_t fp_len,
  input  cnt_t sw_len,
  output cnt_t cnt,
  output logic wrap,
  output logic in_act,
  output logic in_sync
);

  localparam int EXT_W = CRT_CNT_W + 2;
  typedef logic [EXT_W-1:0] ext_t;

  ext_t total, pos_next, sync_lo, sync_hi, pos;
  logic last;
  cnt_t cnt_d;

  assign pos      = ext_t'(cnt);
  assign total    = ext_t'(act_len) + ext_t'(blk_len);
  assign pos_next = pos + ext_t'(1);
  assign last     = (pos_next >= total);
  assign wrap     = step & last;

  assign sync_lo  = ext_t'(act_len) + ext_t'(fp_len);
  assign sync_hi  = sync_lo + ext_t'(sw_len);
  assign in_act   = (pos < ext_t'(act_len));
  assign in_sync  = (pos >= sync_lo) && (pos < sync_hi);

  always_comb begin
    cnt_d = cnt;
    if (step) begin
      cnt_d = last ? '0 : cnt + cnt_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/crt_fetch_addr.sv
module crt_fetch_addr
  import crt_pkg::*;
#(
  parameter addr_t RST_BASE = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_end,
  input  logic  line_end,
  input  cnt_t  v_cnt,
  input  cnt_t  v_act,
  input  logic  zoom,
  input  addr_t pitch,
  input  addr_t next_base,
  input  cnt_t  h_cnt,
  output addr_t fetch_addr
);

  addr_t line_addr, line_addr_d;
  logic  adv_ok;

  // with zoom, only the second line of each displayed pair moves on
  assign adv_ok = (v_cnt < v_act) && (!zoom || v_cnt[0]);

  always_comb begin
    line_addr_d = line_addr;
    if (frame_end) begin
      line_addr_d = next_base;
    end else if (line_end && adv_ok) begin
      line_addr_d = line_addr + pitch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_addr <= RST_BASE;
    end else begin
      line_addr <= line_addr_d;
    end
  end

  assign fetch_addr = line_addr + (addr_t'(h_cnt) << CRT_UNIT_SHIFT);

endmodule

// File: rtl/crt_raster_gen.sv
module crt_raster_gen
  import crt_pkg::*;
#(
  parameter int RST_SYNC_STAGES = 2,
  parameter int RST_BASE  = 0,
  parameter int RST_PITCH = 64,
  parameter int RST_H_ACT = 8,
  parameter int RST_H_BLK = 4,
  parameter int RST_H_FP  = 1,
  parameter int RST_H_SW  = 2,
  parameter int RST_V_ACT = 6,
  parameter int RST_V_BLK = 3,
  parameter int RST_V_FP  = 1,
  parameter int RST_V_SW  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [7:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        hsync,
  output logic        vsync,
  output logic        blank,
  output logic        active_video,
  output logic        line_irq,
  output logic [31:0] fetch_addr
);

  localparam crt_cfg_t RST_CFG = '{
    zoom:   1'b0,
    hs_inv: 1'b0,
    vs_inv: 1'b0,
    base:   addr_t'(RST_BASE),
    pitch:  addr_t'(RST_PITCH),
    h_act:  cnt_t'(RST_H_ACT),
    h_blk:  cnt_t'(RST_H_BLK),
    h_fp:   cnt_t'(RST_H_FP),
    h_sw:   cnt_t'(RST_H_SW),
    v_act:  cnt_t'(RST_V_ACT),
    v_blk:  cnt_t'(RST_V_BLK),
    v_fp:   cnt_t'(RST_V_FP),
    v_sw:   cnt_t'(RST_V_SW)
  };

  // reset: asserted asynchronously, released on the clock
  logic [RST_SYNC_STAGES-1:0] rst_pipe;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[RST_SYNC_STAGES-1];

  crt_cfg_t cfg_live, cfg_act;
  cnt_t     irq_line;
  cnt_t     h_cnt, v_cnt;
  logic     h_wrap, v_wrap, frame_end;
  logic     h_act_w, v_act_w, h_sync_w, v_sync_w;

  assign frame_end = v_wrap;

  crt_reg_bank #(.RST_CFG(RST_CFG)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .frame_end (frame_end),
    .cur_line  (v_cnt),
    .cfg_live  (cfg_live),
    .cfg_act   (cfg_act),
    .irq_line  (irq_line),
    .rd_data   (rd_data)
  );

  crt_axis_counter u_hcnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step    (1'b1),
    .act_len (cfg_act.h_act),
    .blk_len (cfg_act.h_blk),
    .fp_len  (cfg_act.h_fp),
    .sw_len  (cfg_act.h_sw),
    .cnt     (h_cnt),
    .wrap    (h_wrap),
    .in_act  (h_act_w),
    .in_sync (h_sync_w)
  );

  crt_axis_counter u_vcnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step    (h_wrap),
    .act_len (cfg_act.v_act),
    .blk_len (cfg_act.v_blk),
    .fp_len  (cfg_act.v_fp),
    .sw_len  (cfg_act.v_sw),
    .cnt     (v_cnt),
    .wrap    (v_wrap),
    .in_act  (v_act_w),
    .in_sync (v_sync_w)
  );

  crt_fetch_addr #(.RST_BASE(addr_t'(RST_BASE))) u_addr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .frame_end  (frame_end),
    .line_end   (h_wrap),
    .v_cnt      (v_cnt),
    .v_act      (cfg_act.v_act),
    .zoom       (cfg_act.zoom),
    .pitch      (cfg_act.pitch),
    .next_base  (cfg_live.base),
    .h_cnt      (h_cnt),
    .fetch_addr (fetch_addr)
  );

  assign active_video = h_act_w & v_act_w;
  assign blank        = ~active_video;
  assign hsync        = h_sync_w ^ cfg_act.hs_inv;
  assign vsync        = v_sync_w ^ cfg_act.vs_inv;
  assign line_irq     = (h_cnt == '0) && (v_cnt == irq_line);

endmodule

// File: rtl/crt_raster_checks.sv
module crt_raster_checks
  import crt_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input cnt_t     h_cnt,
  input cnt_t     v_cnt,
  input logic     h_wrap,
  input logic     frame_end,
  input crt_cfg_t cfg_act,
  input crt_cfg_t cfg_live,
  input logic     hsync,
  input logic     vsync,
  input logic     blank,
  input logic [31:0] fetch_addr
);

  // R2: the line position restarts after the last unit
  a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    h_wrap |=> (h_cnt == '0));

  // R2: the line position moves by one unit per cycle
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !h_wrap |=> (h_cnt == cnt_t'($past(h_cnt) + cnt_t'(1))));

  // R9: the line number holds within a line
  a_r9_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !h_wrap |=> $stable(v_cnt));

  // R8: the working set changes only at a frame boundary
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(cfg_act));

  a_r8_shadow_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (cfg_act == $past(cfg_live)));

  // R3: raw syncs only inside blanking
  a_r3_hsync_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync ^ cfg_act.hs_inv) |-> blank);

  a_r3_vsync_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync ^ cfg_act.vs_inv) |-> blank);

  // R6: within a line the fetch address moves one 64-bit unit per cycle
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !h_wrap |=> (fetch_addr == $past(fetch_addr) + 32'd8));

endmodule

bind crt_raster_gen crt_raster_checks u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .h_cnt      (h_cnt),
  .v_cnt      (v_cnt),
  .h_wrap     (h_wrap),
  .frame_end  (frame_end),
  .cfg_act    (cfg_act),
  .cfg_live   (cfg_live),
  .hsync      (hsync),
  .vsync      (vsync),
  .blank      (blank),
  .fetch_addr (fetch_addr)
);

// File: tb/crt_raster_gen_bench.sv
module crt_raster_gen_bench;
  import crt_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic        hsync, vsync, blank, active_video, line_irq;
  logic [31:0] fetch_addr;

  int checks = 0;
  int errors = 0;

  // configuration the bench expects to be active from the next frame
  int b_hact = 8, b_hblk = 4, b_hfp = 1, b_hsw = 2;
  int b_vact = 6, b_vblk = 3, b_vfp = 1, b_vsw = 1;
  int b_base = 0, b_pitch = 64, b_irq = 4095;
  int b_zoom = 0, b_hinv = 0, b_vinv = 0;

  crt_raster_gen u_crt_raster_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .hsync        (hsync),
    .vsync        (vsync),
    .blank        (blank),
    .active_video (active_video),
    .line_irq     (line_irq),
    .fetch_addr   (fetch_addr)
  );

  initial clk = 1'b0;
  always #2ns clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_frame_start;
    logic prev;
    logic found;
    rd_addr = OFS_LINE;
    prev = 1'b1;
    found = 1'b0;
    while (!found) begin
      @(negedge clk);
      if (active_video && !prev && rd_data == 32'd0) found = 1'b1;
      prev = active_video;
    end
  endtask

  // starts on the first cycle of a frame, checks every cycle of it
  task automatic scan_frame(input string sync_req, input string addr_req);
    int htot, vtot;
    htot = b_hact + b_hblk;
    vtot = b_vact + b_vblk;
    rd_addr = OFS_LINE;
    for (int i = 0; i < htot * vtot; i++) begin
      int h, v, lines, adv;
      logic ea, ehs, evs;
      h = i % htot;
      v = i / htot;
      ea  = (h < b_hact) && (v < b_vact);
      ehs = ((h >= b_hact + b_hfp) && (h < b_hact + b_hfp + b_hsw)) ^ b_hinv[0];
      evs = ((v >= b_vact + b_vfp) && (v < b_vact + b_vfp + b_vsw)) ^ b_vinv[0];
      lines = (v < b_vact) ? v : b_vact;
      adv = (b_zoom != 0) ? lines / 2 : lines;
      chk("R2", "active_video", {31'd0, active_video}, {31'd0, ea});
      chk("R4", "blank", {31'd0, blank}, {31'd0, !ea});
      chk(sync_req, "hsync", {31'd0, hsync}, {31'd0, ehs});
      chk(sync_req, "vsync", {31'd0, vsync}, {31'd0, evs});
      chk("R9", "line readback", rd_data, v);
      chk("R10", "line_irq", {31'd0, line_irq},
          {31'd0, (h == 0) && (v == b_irq)});
      chk(addr_req, "fetch_addr", fetch_addr, b_base + adv * b_pitch + h * 8);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = OFS_LINE;
    repeat (3) @(negedge clk);
    chk("R1", "hsync in reset", {31'd0, hsync}, 32'd0);
    chk("R1", "vsync in reset", {31'd0, vsync}, 32'd0);
    chk("R1", "line_irq in reset", {31'd0, line_irq}, 32'd0);
    chk("R1", "fetch_addr in reset", fetch_addr, 32'd0);
    chk("R1", "line in reset", rd_data, 32'd0);
    rd_addr = OFS_IRQ;
    @(negedge clk);
    chk("R1", "irq line reg in reset", rd_data, 32'hFFF);
    rd_addr = OFS_LINE;
    rst_n = 1'b1;
  endtask

  task automatic t_default_frame;
    wait_frame_start();
    scan_frame("R3", "R6");
  endtask

  task automatic t_midframe_write;
    wait_frame_start();
    repeat (14) @(negedge clk);       // h=2, v=1
    reg_write(OFS_HACT, 32'd6);       // now h=3
    b_hact = 6;
    repeat (4) @(negedge clk);        // h=7, v=1: active under old width only
    chk("R8", "old width kept in frame", {31'd0, active_video}, 32'd1);
    rd_addr = OFS_HACT;
    @(negedge clk);
    chk("R11", "hact readback", rd_data, 32'd6);
    wait_frame_start();
    scan_frame("R3", "R8");
  endtask

  task automatic t_zoom;
    reg_write(OFS_CTRL, 32'h1);
    reg_write(OFS_BASE, 32'h1000);
    reg_write(OFS_PITCH, 32'h40);
    reg_write(OFS_IRQ, 32'd3);
    b_zoom = 1; b_base = 32'h1000; b_pitch = 32'h40; b_irq = 3;
    wait_frame_start();
    scan_frame("R3", "R7");
  endtask

  task automatic t_polarity;
    reg_write(OFS_CTRL, 32'h6);
    reg_write(OFS_HACT, 32'd5);
    reg_write(OFS_HBLK, 32'd7);
    reg_write(OFS_HFP, 32'd2);
    reg_write(OFS_HSW, 32'd3);
    reg_write(OFS_VACT, 32'd4);
    reg_write(OFS_VBLK, 32'd4);
    reg_write(OFS_VFP, 32'd1);
    reg_write(OFS_VSW, 32'd2);
    reg_write(OFS_IRQ, 32'd0);
    b_zoom = 0; b_hinv = 1; b_vinv = 1;
    b_hact = 5; b_hblk = 7; b_hfp = 2; b_hsw = 3;
    b_vact = 4; b_vblk = 4; b_vfp = 1; b_vsw = 2; b_irq = 0;
    wait_frame_start();
    scan_frame("R5", "R6");
  endtask

  task automatic t_readback;
    logic [31:0] line_v;
    reg_write(OFS_LINE, 32'h55);
    reg_write(8'h3C, 32'hFFFF_FFFF);
    reg_write(OFS_PITCH, 32'hDEAD_BEE0);
    reg_write(OFS_VFP, 32'hFFFF_F002);
    b_vfp = 2;
    rd_addr = OFS_CTRL;  @(negedge clk); chk("R11", "ctrl", rd_data, 32'h6);
    rd_addr = OFS_BASE;  @(negedge clk); chk("R11", "base", rd_data, 32'h1000);
    rd_addr = OFS_PITCH; @(negedge clk); chk("R11", "pitch", rd_data, 32'hDEAD_BEE0);
    rd_addr = OFS_HBLK;  @(negedge clk); chk("R11", "hblk", rd_data, 32'd7);
    rd_addr = OFS_VFP;   @(negedge clk); chk("R11", "vfp cut to 12 bits", rd_data, 32'h002);
    rd_addr = OFS_VSW;   @(negedge clk); chk("R11", "vsw", rd_data, 32'd2);
    rd_addr = OFS_IRQ;   @(negedge clk); chk("R11", "irq line", rd_data, 32'd0);
    rd_addr = 8'h3C;     @(negedge clk); chk("R11", "unmapped reads 0", rd_data, 32'd0);
    rd_addr = OFS_LINE;  @(negedge clk);
    line_v = rd_data;
    chk("R11", "line write ignored", {31'd0, line_v < 32'd8}, 32'd1);
    b_pitch = 32'hDEAD_BEE0;
    wait_frame_start();
    scan_frame("R5", "R6");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_default_frame();
    t_midframe_write();
    t_zoom();
    t_polarity();
    t_readback();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule